// File: doc/BRIEF.md
# UART Control, Status and Interrupt Register Block

This block is the software-facing control core of a memory-mapped UART. It sits on a simple 32-bit register bus with a single-cycle write strobe and a combinational read path. Through it, software turns the transmitter and the receiver on and off with one-shot command strobes. It reads a live status word and manages a small set of sticky interrupt flags. Each flag can be set or cleared through dedicated alias addresses, and an enable mask selects which flags reach the two interrupt lines. The serial shifter, the baud generator and the pin routing live elsewhere. They report to this block through single-cycle event pulses and two level inputs: the occupancy of the two-entry transmit buffer and a receive-data-available level.

The transmit-buffer-level condition is not a stored flag. It is derived each cycle from the buffer occupancy, and a control bit chooses its meaning: "buffer completely empty" or "at least one slot free". Software therefore never clears it. It drops by itself when the buffer fills. A separate transmission-complete status bit is set by the shifter's completion pulse and cleared once new data occupies the buffer.

The block carries no data stream: every pin is a plain control or status signal, so no valid/ready handshake or back-pressure applies.

Top module: `uart_ctl_regs`

## Requirements
- R1: After reset the receiver and transmitter enables, the sync-mode bit, the buffer-mode bit, the interrupt enable mask, the stored flags and the transmission-complete status are all 0, and both interrupt lines are low.
- R2: A write to the command register (offset 0x0C) acts for one cycle only: data bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter, bit 3 disables it. An enable and a disable for the same direction written together leave that direction disabled. Zero bits leave the state unchanged. The command register reads 0.
- R3: The stored flags are IF (offset 0x40) bits 0 (transmit complete event), 2 (receive data event) and 4 (receive overflow event). Writing ones to offset 0x44 sets the matching flags and writing ones to 0x48 clears them, visible the cycle after the write. A bit written to both aliases at once is set. The alias addresses read 0.
- R4: A hardware event pulse (tx_done_evt, rx_data_evt, rx_ovf_evt) sets its flag on the next edge, even when a clear of that flag is written in the same cycle.
- R5: The buffer-level condition appears as IF bit 1 and STATUS bit 6. With CTRL bit 12 set, it holds only when tx_buf_cnt is 0. With that bit clear, it holds when tx_buf_cnt is below 2. Writes to bit 1 through either alias have no effect on it.
- R6: irq_tx is high when IF bit 0 or 1 is set together with the same bit of the enable mask (offset 0x4C, bits 4:0 writable). irq_rx does the same for IF bits 2 and 4.
- R7: STATUS (offset 0x10) bit 0 shows the receiver enabled, bit 1 the transmitter enabled and bit 7 the rx_avail input. Bit 5, transmission complete, is set on the edge after a tx_done_evt pulse. It is cleared on an edge where tx_buf_cnt is nonzero and no pulse arrives.
- R8: CTRL (offset 0x00) keeps only bit 0, synchronous mode, which drives sync_mode, and bit 12, the buffer-mode select. All other CTRL bits read 0.
- R9: Reads of offsets outside the mapped set (for example 0x04 and 0x34) return 0, and bus_rdata is 0 while bus_sel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| tx_done_evt | input | 1 | Pulse: last frame left the shifter |
| rx_data_evt | input | 1 | Pulse: a received word was stored |
| rx_ovf_evt | input | 1 | Pulse: a received word was lost |
| tx_buf_cnt | input | 2 | Occupancy of the transmit buffer, 0 to 2 |
| rx_avail | input | 1 | Level: received data waiting |
| tx_enabled | output | 1 | Transmitter enable state |
| rx_enabled | output | 1 | Receiver enable state |
| sync_mode | output | 1 | Synchronous mode select |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |

## Verification
Two pairs of functions can collide in one cycle: a hardware event pulse and a software clear of the same flag, and the enable and disable strobes of one direction in a single command write. Directed cases drive exactly those overlaps and expect the flag set and the direction disabled. Random cycles draw register writes and event pulses independently, so the overlaps also recur with random neighbours. Every cycle is judged against a bench model that reads back IF, STATUS, IEN and CTRL and compares the interrupt lines and enable outputs.

// File: rtl/ucr_pkg.sv
package ucr_pkg;
  localparam int unsigned OFS_CTRL   = 32'h00;
  localparam int unsigned OFS_CMD    = 32'h0C;
  localparam int unsigned OFS_STATUS = 32'h10;
  localparam int unsigned OFS_IF     = 32'h40;
  localparam int unsigned OFS_IFS    = 32'h44;
  localparam int unsigned OFS_IFC    = 32'h48;
  localparam int unsigned OFS_IEN    = 32'h4C;

  localparam int unsigned CTRL_SYNC_BIT = 0;
  localparam int unsigned CTRL_BIL_BIT  = 12;

  // stored flag i sits at IF bit 2*i; bit 1 is the derived buffer level
  localparam int unsigned NFLAG     = 3;
  localparam int unsigned IF_W      = 2 * NFLAG - 1;
  localparam int unsigned IF_LVL_BIT = 1;
  localparam logic [IF_W-1:0] TX_IRQ_MASK = 5'b00011;
  localparam logic [IF_W-1:0] RX_IRQ_MASK = 5'b10100;

  localparam int unsigned ST_RXEN_BIT = 0;
  localparam int unsigned ST_TXEN_BIT = 1;
  localparam int unsigned ST_TXC_BIT  = 5;
  localparam int unsigned ST_LVL_BIT  = 6;
  localparam int unsigned ST_RXAV_BIT = 7;

  // direction index used by the command strobes
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;
endpackage

// File: rtl/ucr_cmd.sv
module ucr_cmd #(
  parameter int unsigned NDIR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDIR-1:0] en_stb,
  input  logic [NDIR-1:0] dis_stb,
  output logic [NDIR-1:0] en_q
);
  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          en_q[d] <= 1'b0;
      else if (dis_stb[d]) en_q[d] <= 1'b0;
      else if (en_stb[d])  en_q[d] <= 1'b1;
    end

    // R2: disable strobe wins over a simultaneous enable
    p_dis_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dis_stb[d] |=> !en_q[d]);
    // R2: with no strobe the state holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_stb[d] || dis_stb[d]) |=> $stable(en_q[d]));
  end
endmodule

// File: rtl/ucr_flags.sv
module ucr_flags #(
  parameter int unsigned NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] sw_set,
  input  logic [NF-1:0] sw_clr,
  input  logic [NF-1:0] hw_evt,
  output logic [NF-1:0] flag_q
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       flag_q[i] <= 1'b0;
      else if (hw_evt[i] || sw_set[i])  flag_q[i] <= 1'b1;
      else if (sw_clr[i])               flag_q[i] <= 1'b0;
    end

    // R4: an event sets the flag even against a clear
    p_evt_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hw_evt[i] |=> flag_q[i]);
    // R3: a lone clear drops the flag
    p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr[i] && !sw_set[i] && !hw_evt[i]) |=> !flag_q[i]);
  end
endmodule

// File: rtl/ucr_txbuf.sv
module ucr_txbuf #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             empty_mode,
  input  logic             done_evt,
  output logic             level_ok,
  output logic             txc_q
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  always_comb begin
    if (empty_mode) level_ok = (cnt == '0);
    else            level_ok = (cnt < FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           txc_q <= 1'b0;
    else if (done_evt)    txc_q <= 1'b1;
    else if (cnt != '0)   txc_q <= 1'b0;
  end

  // R5: a full buffer never shows level, an empty one always does
  p_full_nolvl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= FULL) |-> !level_ok);
  p_empty_lvl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> level_ok);
  // R7: completion pulse sets status
  p_txc_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> txc_q);
endmodule

// File: rtl/uart_ctl_regs.sv
module uart_ctl_regs
  import ucr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TXBUF_DEPTH = 2,
  parameter int unsigned CNT_W       = $clog2(TXBUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_done_evt,
  input  logic              rx_data_evt,
  input  logic              rx_ovf_evt,
  input  logic [CNT_W-1:0]  tx_buf_cnt,
  input  logic              rx_avail,
  output logic              tx_enabled,
  output logic              rx_enabled,
  output logic              sync_mode,
  output logic              irq_rx,
  output logic              irq_tx
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_IF     = ADDR_W'(OFS_IF);
  localparam logic [ADDR_W-1:0] A_IFS    = ADDR_W'(OFS_IFS);
  localparam logic [ADDR_W-1:0] A_IFC    = ADDR_W'(OFS_IFC);
  localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(OFS_IEN);

  logic wr_go;
  logic wr_ctrl, wr_cmd, wr_ifs, wr_ifc, wr_ien;
  assign wr_go   = bus_sel && bus_wr;
  assign wr_ctrl = wr_go && (bus_addr == A_CTRL);
  assign wr_cmd  = wr_go && (bus_addr == A_CMD);
  assign wr_ifs  = wr_go && (bus_addr == A_IFS);
  assign wr_ifc  = wr_go && (bus_addr == A_IFC);
  assign wr_ien  = wr_go && (bus_addr == A_IEN);

  // control and mask registers
  logic            ctrl_sync_q, ctrl_bil_q;
  logic [IF_W-1:0] ien_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_sync_q <= 1'b0;
      ctrl_bil_q  <= 1'b0;
      ien_q       <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_sync_q <= bus_wdata[CTRL_SYNC_BIT];
        ctrl_bil_q  <= bus_wdata[CTRL_BIL_BIT];
      end
      if (wr_ien) ien_q <= bus_wdata[IF_W-1:0];
    end
  end
  assign sync_mode = ctrl_sync_q;

  // command strobes: per direction, enable at bit 2*d, disable at 2*d+1
  logic [1:0] en_stb, dis_stb, en_q;
  for (genvar d = 0; d < 2; d++) begin : g_stb
    assign en_stb[d]  = wr_cmd && bus_wdata[2*d];
    assign dis_stb[d] = wr_cmd && bus_wdata[2*d+1];
  end

  ucr_cmd #(.NDIR(2)) u_cmd (
    .clk(clk), .rst_n(rst_n), .en_stb(en_stb), .dis_stb(dis_stb), .en_q(en_q)
  );
  assign rx_enabled = en_q[DIR_RX];
  assign tx_enabled = en_q[DIR_TX];

  // sticky flags
  logic [NFLAG-1:0] f_set, f_clr, f_evt, f_q;
  for (genvar i = 0; i < NFLAG; i++) begin : g_fmap
    assign f_set[i] = wr_ifs && bus_wdata[2*i];
    assign f_clr[i] = wr_ifc && bus_wdata[2*i];
  end
  assign f_evt = {rx_ovf_evt, rx_data_evt, tx_done_evt};

  ucr_flags #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .sw_set(f_set), .sw_clr(f_clr),
    .hw_evt(f_evt), .flag_q(f_q)
  );

  logic level_ok, txc_st;
  ucr_txbuf #(.DEPTH(TXBUF_DEPTH), .CNT_W(CNT_W)) u_txbuf (
    .clk(clk), .rst_n(rst_n), .cnt(tx_buf_cnt), .empty_mode(ctrl_bil_q),
    .done_evt(tx_done_evt), .level_ok(level_ok), .txc_q(txc_st)
  );

  logic [IF_W-1:0] if_vec;
  always_comb begin
    if_vec = '0;
    for (int i = 0; i < int'(NFLAG); i++) if_vec[2*i] = f_q[i];
    if_vec[IF_LVL_BIT] = level_ok;
  end

  assign irq_tx = |(if_vec & ien_q & TX_IRQ_MASK);
  assign irq_rx = |(if_vec & ien_q & RX_IRQ_MASK);

  // read path
  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        A_CTRL: begin
          bus_rdata[CTRL_SYNC_BIT] = ctrl_sync_q;
          bus_rdata[CTRL_BIL_BIT]  = ctrl_bil_q;
        end
        A_STATUS: begin
          bus_rdata[ST_RXEN_BIT] = en_q[DIR_RX];
          bus_rdata[ST_TXEN_BIT] = en_q[DIR_TX];
          bus_rdata[ST_TXC_BIT]  = txc_st;
          bus_rdata[ST_LVL_BIT]  = level_ok;
          bus_rdata[ST_RXAV_BIT] = rx_avail;
        end
        A_IF:    bus_rdata[IF_W-1:0] = if_vec;
        A_IEN:   bus_rdata[IF_W-1:0] = ien_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // R6: an empty mask keeps both lines quiet
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> (!irq_rx && !irq_tx));
  // R8: sync output follows the written CTRL bit
  p_sync_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (sync_mode == $past(bus_wdata[CTRL_SYNC_BIT])));
endmodule

// File: tb/uart_ctl_regs_bench.sv
module uart_ctl_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_done_evt = 0, rx_data_evt = 0, rx_ovf_evt = 0;
  logic [1:0]  tx_buf_cnt = 2'd2;
  logic        rx_avail = 0;
  logic        tx_enabled, rx_enabled, sync_mode, irq_rx, irq_tx;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_ctl_regs u_uart_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_done_evt(tx_done_evt), .rx_data_evt(rx_data_evt), .rx_ovf_evt(rx_ovf_evt),
    .tx_buf_cnt(tx_buf_cnt), .rx_avail(rx_avail), .tx_enabled(tx_enabled),
    .rx_enabled(rx_enabled), .sync_mode(sync_mode), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  // bench model
  bit m_rx, m_tx, m_sync, m_bil, m_txc;
  bit [2:0] m_f;     // IF bits 0,2,4
  bit [4:0] m_ien;

  function automatic bit lvl(bit [1:0] c, bit b);
    return b ? (c == 0) : (c < 2);
  endfunction
  function automatic bit [31:0] exp_if();
    bit [31:0] v = 0;
    v[0] = m_f[0]; v[2] = m_f[1]; v[4] = m_f[2]; v[1] = lvl(tx_buf_cnt, m_bil);
    return v;
  endfunction
  function automatic bit [31:0] exp_st();
    bit [31:0] v = 0;
    v[0] = m_rx; v[1] = m_tx; v[5] = m_txc; v[6] = lvl(tx_buf_cnt, m_bil); v[7] = rx_avail;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(string req, bit [7:0] a, bit [31:0] exp);
    bus_sel = 1; bus_wr = 0; bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  // full readback at a negedge
  task automatic check_all();
    bit [31:0] e_if = exp_if();
    bit [31:0] e_ctrl = 0;
    e_ctrl[0] = m_sync; e_ctrl[12] = m_bil;
    rd("R3 IF", 8'h40, e_if);
    rd("R7 STATUS", 8'h10, exp_st());
    rd("R6 IEN", 8'h4C, {27'b0, m_ien});
    rd("R8 CTRL", 8'h00, e_ctrl);
    chk("R2 rx_enabled", rx_enabled, m_rx);
    chk("R2 tx_enabled", tx_enabled, m_tx);
    chk("R8 sync_mode", sync_mode, m_sync);
    chk("R6 irq_tx", irq_tx, |(e_if[4:0] & m_ien & 5'b00011));
    chk("R6 irq_rx", irq_rx, |(e_if[4:0] & m_ien & 5'b10100));
  endtask

  // one clock: drive at negedge, model the edge, check at the next negedge
  task automatic step(bit wr, bit [7:0] a, bit [31:0] d, bit [2:0] ev, bit [1:0] c, bit av);
    bit [2:0] s, k;
    bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d;
    {rx_ovf_evt, rx_data_evt, tx_done_evt} = ev;
    tx_buf_cnt = c; rx_avail = av;
    @(posedge clk);
    s = 0; k = 0;
    if (wr) begin
      case (a)
        8'h00: begin m_sync = d[0]; m_bil = d[12]; end
        8'h0C: begin
          if (d[1]) m_rx = 0; else if (d[0]) m_rx = 1;
          if (d[3]) m_tx = 0; else if (d[2]) m_tx = 1;
        end
        8'h44: s = {d[4], d[2], d[0]};
        8'h48: k = {d[4], d[2], d[0]};
        8'h4C: m_ien = d[4:0];
        default: ;
      endcase
    end
    m_f = (m_f & ~k) | s | ev;
    if (ev[0]) m_txc = 1; else if (c != 0) m_txc = 0;
    @(negedge clk);
    bus_wr = 0; bus_sel = 0; bus_wdata = 0;
    {rx_ovf_evt, rx_data_evt, tx_done_evt} = 0;
    check_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check_all();
    chk("R1 irq_rx low", irq_rx, 0);
    rd("R1 IF zero", 8'h40, 32'h0);
    // R9 unmapped and write-only reads
    rd("R9 offset 04", 8'h04, 0);
    rd("R9 offset 34", 8'h34, 0);
    rd("R2 CMD reads 0", 8'h0C, 0);
    rd("R3 IFS reads 0", 8'h44, 0);
    bus_sel = 0; bus_addr = 8'h10; #1; chk("R9 no sel", bus_rdata, 0);
    // R2 enable both, then enable+disable rx together
    step(1, 8'h0C, 32'h5, 0, 2, 0);
    chk("R2 both on", {rx_enabled, tx_enabled}, 2'b11);
    step(1, 8'h0C, 32'h3, 0, 2, 0);
    chk("R2 rx en+dis -> off", rx_enabled, 0);
    step(1, 8'h0C, 32'h0, 0, 2, 0);
    chk("R2 zero write holds tx", tx_enabled, 1);
    // R6 enable all, R3 set via IFS, both aliases at once
    step(1, 8'h4C, 32'h1F, 0, 2, 0);
    step(1, 8'h44, 32'h15, 0, 2, 0);
    chk("R3 IFS sets", irq_rx, 1);
    step(1, 8'h48, 32'h15, 0, 2, 0);
    chk("R3 IFC clears", {irq_rx, irq_tx}, 2'b00);
    step(1, 8'h48, 32'h04, 0, 2, 0);
    step(1, 8'h44, 32'h04, 0, 2, 0);
    // R4 event against clear in same cycle
    step(1, 8'h48, 32'h15, 3'b111, 2, 0);
    rd("R4 event beats clear", 8'h40, 32'h15);
    // R5 level modes; alias writes to bit 1 ignored
    step(1, 8'h48, 32'h15, 0, 1, 0);
    rd("R5 has-room mode cnt1", 8'h40, 32'h2);
    step(1, 8'h00, 32'h1000, 0, 1, 0);
    rd("R5 empty mode cnt1", 8'h40, 32'h0);
    step(1, 8'h44, 32'h2, 0, 1, 0);
    rd("R5 IFS bit1 ignored", 8'h40, 32'h0);
    step(0, 0, 0, 0, 0, 1);
    rd("R5 empty mode cnt0", 8'h10, 32'h0000_00C2);
    // R7 completion status set then cleared by new data
    step(0, 0, 0, 3'b001, 1, 0);
    rd("R7 txc set", 8'h10, 32'h0000_0022);
    step(0, 0, 0, 0, 1, 0);
    rd("R7 txc cleared", 8'h10, 32'h0000_0002);
    // random phase
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] addrs [7] = '{8'h00, 8'h0C, 8'h44, 8'h48, 8'h4C, 8'h10, 8'h34};
      bit [31:0] d = $urandom;
      step($urandom_range(0, 1), addrs[$urandom_range(0, 6)], d,
           3'($urandom_range(0, 7) & $urandom_range(0, 7)),
           2'($urandom_range(0, 2)), 1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule